// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns one instruction's addressing information into the address of its operand. Each request carries a four-bit mode code, a short address or displacement field, a register selector and the current program counter. The unit reads one register from an external register file. It combines that value with the field or the program counter as the mode requires. It returns the effective address, or the operand itself for immediate mode, together with a one-cycle valid pulse.

Memory-indirect mode needs a pointer from memory. For that mode the unit issues a read on a simple request/acknowledge port and waits for the acknowledge. The auto-increment, auto-decrement, push and pop modes change a register. The unit returns the new register value through a write port in the same cycle that the result is valid. The caller owns the register file and must apply that write.

A new request is taken only while `ready` is high. `ready` stays low while a memory read is pending and during the valid cycle. This ensures that a register updated by one request is written before the next request reads it.

Top module: `ea_gen_unit`

## Requirements
- R1: After reset, `ea_valid`, `rf_we` and `mem_req` are low and `ready` is high.
- R2: Mode 0 (immediate) returns the field zero-extended to the data width, with `ea_is_operand` high. It issues no memory request.
- R3: Mode 1 (direct) returns the zero-extended field as the address, with `ea_is_operand` low.
- R4: Mode 2 (memory indirect) raises `mem_req` in the cycle after acceptance, with `mem_addr` equal to the zero-extended field. Both stay unchanged until a cycle in which `mem_ack` is high. `ea_valid` stays low while the read is pending. In the cycle after the acknowledge, `ea_out` carries the `mem_rdata` sampled in the acknowledge cycle.
- R5: Mode 3 (register indirect) returns the value of the register chosen by `r_sel`.
- R6: Mode 4 (displacement/base/indexed) returns the zero-extended field plus the selected register, modulo 2^DATA_W.
- R7: Mode 5 (PC-relative) returns `pc` plus the field taken as a two's-complement number, sign-extended, modulo 2^DATA_W.
- R8: Mode 6 (post-increment) returns the selected register's old value. It writes old value + 1 (wrapping) back to that register, with `rf_we` high in the valid cycle.
- R9: Mode 7 (pre-decrement) returns the selected register minus 1 (wrapping). It writes the same value back to that register in the valid cycle.
- R10: Mode 8 (push) and mode 9 (pop) use register NREG-1 as stack pointer and ignore `r_sel`. Push returns and writes back SP-1. Pop returns SP and writes back SP+1.
- R11: For every mode except 2, `ea_valid` is high exactly in the cycle after acceptance. `ea_valid` is always a single-cycle pulse. `ready` is low during that pulse.
- R12: Mode codes 10 to 15 behave as direct mode and cause no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when `ready` is high |
| mode | input | 4 | Addressing mode code |
| a_fld | input | FIELD_W | Address / displacement / immediate field |
| r_sel | input | RSEL_W | Register selector |
| pc | input | DATA_W | Program counter of the instruction |
| ready | output | 1 | Unit can accept a request this cycle |
| ea_valid | output | 1 | Result valid pulse |
| ea_out | output | DATA_W | Effective address or immediate operand |
| ea_is_operand | output | 1 | Result is an operand value (immediate) |
| rf_raddr | output | RSEL_W | Register file read index |
| rf_rdata | input | DATA_W | Register file read data (combinational) |
| rf_we | output | 1 | Register writeback enable |
| rf_waddr | output | RSEL_W | Register writeback index |
| rf_wdata | output | DATA_W | Register writeback value |
| mem_req | output | 1 | Pointer read request, held until acknowledged |
| mem_addr | output | DATA_W | Pointer read address |
| mem_ack | input | 1 | Pointer read acknowledge, one cycle |
| mem_rdata | input | DATA_W | Pointer read data, valid with `mem_ack` |

## Verification
The embedded properties rely on three assumptions about the environment:
- `rf_rdata` reflects `rf_raddr` combinationally within the cycle.
- `mem_ack` arrives only while `mem_req` is high, and for one cycle.
- The writeback is applied before `ready` returns.

The bench's register model reads with no delay and commits writes at the next edge. Its memory model raises one acknowledge after a chosen latency of zero or more cycles and then clears it. Requests are issued only when `ready` is seen high, so no property ever sees a request the unit could not take.

// File: rtl/ea_pkg.sv
// Package ea_pkg
// Shared mode encoding for the effective address generation unit.
// Codes 10..15 are reserved and are handled like direct mode.
package ea_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_IMM  = 4'd0,
        MD_DIR  = 4'd1,
        MD_IND  = 4'd2,
        MD_RIND = 4'd3,
        MD_DISP = 4'd4,
        MD_REL  = 4'd5,
        MD_AINC = 4'd6,
        MD_ADEC = 4'd7,
        MD_PUSH = 4'd8,
        MD_POP  = 4'd9
    } ea_mode_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_FETCH = 1'b1
    } ea_state_e;
endpackage

// File: rtl/ea_calc.sv
// Module ea_calc
// Combinational datapath. It selects the register to read, forms the
// effective address for each mode and computes the writeback for the
// modes that update a register.
// Assumes FIELD_W <= DATA_W and that rval is the value of rd_idx in the
// same cycle.
module ea_calc
    import ea_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 12,
    parameter int NREG    = 8,
    localparam int RSEL_W = $clog2(NREG),
    localparam int SP_IDX = NREG - 1
) (
    input  logic [MODE_W-1:0]  mode,
    input  logic [FIELD_W-1:0] a_fld,
    input  logic [RSEL_W-1:0]  r_sel,
    input  logic [DATA_W-1:0]  rval,
    input  logic [DATA_W-1:0]  pc,
    output logic [RSEL_W-1:0]  rd_idx,
    output logic [DATA_W-1:0]  ea,
    output logic [DATA_W-1:0]  a_zext,
    output logic               is_imm,
    output logic               needs_mem,
    output logic               wb_en,
    output logic [RSEL_W-1:0]  wb_idx,
    output logic [DATA_W-1:0]  wb_val
);
    logic [DATA_W-1:0] a_sext;
    logic [DATA_W-1:0] r_inc;
    logic [DATA_W-1:0] r_dec;
    logic              is_stack;

    // Widen the field, zero- or sign-filled; the variant depends on the widths.
    generate
        if (FIELD_W == DATA_W) begin : g_same_w
            assign a_zext = a_fld;
            assign a_sext = a_fld;
        end else begin : g_extend
            assign a_zext = {{(DATA_W-FIELD_W){1'b0}}, a_fld};
            assign a_sext = {{(DATA_W-FIELD_W){a_fld[FIELD_W-1]}}, a_fld};
        end
    endgenerate

    assign r_inc    = rval + DATA_W'(1);
    assign r_dec    = rval - DATA_W'(1);
    assign is_stack = (mode == MD_PUSH) || (mode == MD_POP);
    assign rd_idx   = is_stack ? RSEL_W'(SP_IDX) : r_sel;
    assign wb_idx   = rd_idx;

    // Per-mode address, operand flag, memory need and writeback.
    always_comb begin
        ea        = a_zext;
        is_imm    = 1'b0;
        needs_mem = 1'b0;
        wb_en     = 1'b0;
        wb_val    = rval;
        case (mode)
            MD_IMM:  is_imm    = 1'b1;
            MD_DIR:  ea        = a_zext;
            MD_IND:  needs_mem = 1'b1;
            MD_RIND: ea        = rval;
            MD_DISP: ea        = a_zext + rval;
            MD_REL:  ea        = pc + a_sext;
            MD_AINC: begin
                ea     = rval;
                wb_en  = 1'b1;
                wb_val = r_inc;
            end
            MD_ADEC, MD_PUSH: begin
                ea     = r_dec;
                wb_en  = 1'b1;
                wb_val = r_dec;
            end
            MD_POP: begin
                ea     = rval;
                wb_en  = 1'b1;
                wb_val = r_inc;
            end
            default: ea = a_zext;
        endcase
    end
endmodule

// File: rtl/ea_seq.sv
// Module ea_seq
// Control and output registers. Single-cycle modes give their result in
// the cycle after acceptance. Indirect mode holds a memory request until it
// is acknowledged, then gives the returned word one cycle later. The
// writeback is registered next to the valid pulse.
// Assumes mem_ack is high only while mem_req is high.
module ea_seq
    import ea_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc,
    input  logic              needs_mem,
    input  logic [DATA_W-1:0] ea_in,
    input  logic [DATA_W-1:0] mem_addr_in,
    input  logic              is_imm_in,
    input  logic              wb_en_in,
    input  logic [RSEL_W-1:0] wb_idx_in,
    input  logic [DATA_W-1:0] wb_val_in,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ready,
    output logic              valid_q,
    output logic [DATA_W-1:0] ea_q,
    output logic              imm_q,
    output logic              we_q,
    output logic [RSEL_W-1:0] waddr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              req_q,
    output logic [DATA_W-1:0] maddr_q
);
    ea_state_e state;

    // Ready only when idle and not presenting a result.
    assign ready = (state == S_IDLE) && !valid_q;

    // Sequencing of requests, pointer fetch and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            valid_q <= 1'b0;
            ea_q    <= '0;
            imm_q   <= 1'b0;
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
            req_q   <= 1'b0;
            maddr_q <= '0;
        end else begin
            valid_q <= 1'b0;
            we_q    <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start_acc) begin
                        if (needs_mem) begin
                            state   <= S_FETCH;
                            req_q   <= 1'b1;
                            maddr_q <= mem_addr_in;
                        end else begin
                            valid_q <= 1'b1;
                            ea_q    <= ea_in;
                            imm_q   <= is_imm_in;
                            we_q    <= wb_en_in;
                            waddr_q <= wb_idx_in;
                            wdata_q <= wb_val_in;
                        end
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        state   <= S_IDLE;
                        req_q   <= 1'b0;
                        valid_q <= 1'b1;
                        ea_q    <= mem_rdata;
                        imm_q   <= 1'b0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: the valid strobe never lasts two cycles.
    a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R11: no request can be taken while a result is shown.
    a_r11_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !ready);

    // R4: request and address hold until acknowledged.
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !mem_ack) |=> (req_q && $stable(maddr_q)));

    // R4: no result while the pointer read is pending.
    a_r4_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> !valid_q);

    // R8: a register write happens only with a valid result.
    a_r8_wb_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> valid_q);
endmodule

// File: rtl/ea_gen_unit.sv
// Module ea_gen_unit
// Top of the effective address generation unit. It joins the mode
// datapath to the sequencer. The register file is external: the read is
// combinational through rf_raddr/rf_rdata, and the writeback is
// presented with the valid pulse.
// Assumes the caller applies rf_we before ready rises again.
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 12,
    parameter int NREG    = 8,
    localparam int RSEL_W = $clog2(NREG),
    localparam int SP_IDX = NREG - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MODE_W-1:0]  mode,
    input  logic [FIELD_W-1:0] a_fld,
    input  logic [RSEL_W-1:0]  r_sel,
    input  logic [DATA_W-1:0]  pc,
    output logic               ready,
    output logic               ea_valid,
    output logic [DATA_W-1:0]  ea_out,
    output logic               ea_is_operand,
    output logic [RSEL_W-1:0]  rf_raddr,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic               rf_we,
    output logic [RSEL_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               mem_req,
    output logic [DATA_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata
);
    logic              start_acc;
    logic [DATA_W-1:0] c_ea;
    logic [DATA_W-1:0] c_azx;
    logic              c_imm;
    logic              c_mem;
    logic              c_wen;
    logic [RSEL_W-1:0] c_widx;
    logic [DATA_W-1:0] c_wval;

    assign start_acc = start && ready;

    ea_calc #(
        .DATA_W (DATA_W),
        .FIELD_W(FIELD_W),
        .NREG   (NREG)
    ) u_calc (
        .mode     (mode),
        .a_fld    (a_fld),
        .r_sel    (r_sel),
        .rval     (rf_rdata),
        .pc       (pc),
        .rd_idx   (rf_raddr),
        .ea       (c_ea),
        .a_zext   (c_azx),
        .is_imm   (c_imm),
        .needs_mem(c_mem),
        .wb_en    (c_wen),
        .wb_idx   (c_widx),
        .wb_val   (c_wval)
    );

    ea_seq #(
        .DATA_W(DATA_W),
        .RSEL_W(RSEL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_acc  (start_acc),
        .needs_mem  (c_mem),
        .ea_in      (c_ea),
        .mem_addr_in(c_azx),
        .is_imm_in  (c_imm),
        .wb_en_in   (c_wen),
        .wb_idx_in  (c_widx),
        .wb_val_in  (c_wval),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .ready      (ready),
        .valid_q    (ea_valid),
        .ea_q       (ea_out),
        .imm_q      (ea_is_operand),
        .we_q       (rf_we),
        .waddr_q    (rf_waddr),
        .wdata_q    (rf_wdata),
        .req_q      (mem_req),
        .maddr_q    (mem_addr)
    );

    // R11: modes without a memory read answer in the next cycle.
    a_r11_next_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && mode != MD_IND) |=> ea_valid);

    // R4: an indirect request starts a read instead of a result.
    a_r4_req_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && mode == MD_IND) |=> (mem_req && !ea_valid));

    // R2: immediate mode never touches memory.
    a_r2_imm_noreq: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && mode == MD_IMM) |=> (!mem_req && ea_is_operand));

    // R9: the pre-decrement result and its writeback agree.
    a_r9_dec_match: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && mode == MD_ADEC) |=> (rf_we && rf_wdata == ea_out));

    // R8: the post-increment writeback is one above the returned address.
    a_r8_inc_match: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && mode == MD_AINC) |=> (rf_we && rf_wdata == ea_out + DATA_W'(1)));

    // R10: stack modes write the stack pointer register.
    a_r10_sp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && (mode == MD_PUSH || mode == MD_POP)) |=>
            (rf_we && rf_waddr == RSEL_W'(SP_IDX)));

    // R12: reserved codes never write a register.
    a_r12_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc && mode > MD_POP) |=> !rf_we);
endmodule

// File: tb/ea_gen_unit_bench.sv
// Scoreboard bench for ea_gen_unit. The driver pushes expected results
// computed from a bench register model. The monitor pops them on each
// valid pulse and compares.
module ea_gen_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int FW = 12;
    localparam int NR = 8;
    localparam int RW = 3;

    typedef struct {
        logic [DW-1:0] ea;
        logic          imm;
        logic          we;
        logic [RW-1:0] waddr;
        logic [DW-1:0] wdata;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [FW-1:0] a_fld = '0;
    logic [RW-1:0] r_sel = '0;
    logic [DW-1:0] pc = '0;
    logic          ready, ea_valid, ea_is_operand;
    logic [DW-1:0] ea_out;
    logic [RW-1:0] rf_raddr, rf_waddr;
    logic [DW-1:0] rf_rdata, rf_wdata;
    logic          rf_we;
    logic          mem_req;
    logic [DW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] regs [NR];
    exp_t          sb[$];
    int            checks = 0;
    int            fails = 0;
    int            mem_lat = 0;
    int            lat_cnt = 0;
    bit            ind_pending = 0;
    bit            stray_req = 0;

    ea_gen_unit u_ea_gen_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .a_fld(a_fld),
        .r_sel(r_sel), .pc(pc), .ready(ready), .ea_valid(ea_valid),
        .ea_out(ea_out), .ea_is_operand(ea_is_operand), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] mem_fn(input logic [DW-1:0] x);
        return (x * 16'h9E37) ^ 16'h5A5A;
    endfunction

    // Register file model: combinational read, write at the edge.
    assign rf_rdata = regs[rf_raddr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) regs[i] <= DW'(16'h1111 * i + 16'h0100);
        end else if (rf_we) begin
            regs[rf_waddr] <= rf_wdata;
        end
    end

    // Memory model: one-cycle acknowledge after mem_lat waiting cycles.
    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt >= mem_lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_fn(mem_addr);
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            lat_cnt <= 0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every valid result against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && !ind_pending) stray_req = 1;
            if (ea_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R11 unexpected valid", ea_out, '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(ea_out == e.ea && ea_is_operand == e.imm,
                          {e.tag, " ea"}, ea_out, e.ea);
                    check(rf_we == e.we && (!e.we || (rf_waddr == e.waddr && rf_wdata == e.wdata)),
                          {e.tag, " writeback"}, rf_we ? rf_wdata : '0, e.we ? e.wdata : '0);
                    ind_pending = 0;
                end
            end
        end
    end

    // Driver: wait for ready, drive a request, push its expected result.
    task automatic issue(input logic [3:0] md, input logic [FW-1:0] a, input logic [RW-1:0] r,
                         input logic [DW-1:0] pcv, input int lat, input string tag);
        exp_t          e;
        logic [DW-1:0] az, as_, rv, sp;
        @(negedge clk);
        while (!ready) @(negedge clk);
        az  = {{(DW-FW){1'b0}}, a};
        as_ = {{(DW-FW){a[FW-1]}}, a};
        rv  = regs[r];
        sp  = regs[NR-1];
        e.ea = az; e.imm = 0; e.we = 0; e.waddr = r; e.wdata = '0; e.tag = tag;
        case (md)
            4'd0: e.imm = 1;
            4'd2: e.ea = mem_fn(az);
            4'd3: e.ea = rv;
            4'd4: e.ea = az + rv;
            4'd5: e.ea = pcv + as_;
            4'd6: begin e.ea = rv; e.we = 1; e.wdata = rv + 1; end
            4'd7: begin e.ea = rv - 1; e.we = 1; e.wdata = rv - 1; end
            4'd8: begin e.ea = sp - 1; e.we = 1; e.waddr = RW'(NR-1); e.wdata = sp - 1; end
            4'd9: begin e.ea = sp; e.we = 1; e.waddr = RW'(NR-1); e.wdata = sp + 1; end
            default: ;
        endcase
        mem_lat = lat;
        if (md == 4'd2) ind_pending = 1;
        sb.push_back(e);
        start = 1; mode = md; a_fld = a; r_sel = r; pc = pcv;
        @(negedge clk);
        start = 0;
        if (md == 4'd2) begin
            check(mem_req && !ea_valid && mem_addr == az, "R4 request", mem_addr, az);
        end else begin
            check(ea_valid && !ready, "R11 next-cycle valid", DW'(ea_valid), DW'(1));
        end
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", '0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check(!ea_valid && !rf_we && !mem_req && ready, "R1 reset state",
              {12'h0, ea_valid, rf_we, mem_req, ready}, 16'h0001);
        issue(4'd0, 12'hFFF, 3'd0, 16'h0000, 0, "R2 immediate");
        issue(4'd1, 12'h7A5, 3'd0, 16'h0000, 0, "R3 direct");
        issue(4'd2, 12'h123, 3'd0, 16'h0000, 0, "R4 indirect lat0");
        issue(4'd2, 12'hABC, 3'd0, 16'h0000, 3, "R4 indirect lat3");
        issue(4'd3, 12'h000, 3'd2, 16'h0000, 0, "R5 register indirect");
        issue(4'd0, 12'h001, 3'd0, 16'h0000, 0, "R2 immediate small");
        issue(4'd4, 12'h020, 3'd5, 16'h0000, 0, "R6 displacement");
        issue(4'd4, 12'hFFF, 3'd7, 16'h0000, 0, "R6 displacement large");
        issue(4'd5, 12'h010, 3'd0, 16'h4000, 0, "R7 relative forward");
        issue(4'd5, 12'hFFE, 3'd0, 16'h4000, 0, "R7 relative backward");
        issue(4'd5, 12'h800, 3'd0, 16'h0100, 0, "R7 relative wrap");
        issue(4'd6, 12'h000, 3'd1, 16'h0000, 0, "R8 post-increment");
        issue(4'd6, 12'h000, 3'd1, 16'h0000, 0, "R8 post-increment again");
        issue(4'd7, 12'h000, 3'd0, 16'h0000, 0, "R9 pre-decrement");
        issue(4'd3, 12'h000, 3'd0, 16'h0000, 0, "R9 register after decrement");
        issue(4'd8, 12'h000, 3'd2, 16'h0000, 0, "R10 push");
        issue(4'd8, 12'h000, 3'd3, 16'h0000, 0, "R10 push again");
        issue(4'd9, 12'h000, 3'd0, 16'h0000, 0, "R10 pop");
        issue(4'd3, 12'h000, 3'd7, 16'h0000, 0, "R10 stack pointer after pop");
        issue(4'd12, 12'h456, 3'd4, 16'h0000, 0, "R12 reserved 12");
        issue(4'd15, 12'h0F0, 3'd3, 16'h0000, 0, "R12 reserved 15");
        issue(4'd3, 12'h000, 3'd3, 16'h0000, 0, "R12 register untouched");
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R11 all results seen", DW'(sb.size()), '0);
        check(!stray_req, "R2 no stray memory request", DW'(stray_req), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule